// File: doc/BRIEF.md
# UART Receive Queue with Per-Character Status

This block sits behind the bit-level receiver of a UART. A decoder upstream samples the line and hands over one finished character per pulse, together with the sampled first stop bit, a parity-mismatch indication and an address marker. The block parks that character in a holding (shift) register. It moves the character into a small receive queue as soon as the queue has room, and presents the oldest stored character on the read data port.

Every queued entry carries its own status: a frame-error bit, a parity-error bit and an overrun tag. The status outputs therefore always describe the character currently at the head. A read strobe advances the queue. The block detects an overrun when the queue is full, the holding register still has a character waiting and another start bit arrives. The overrun travels with the data stream. Turning the receiver off empties everything. In multiprocessor mode, characters without an address marker are discarded before they are stored.

Top module: `uart_rx_queue`

## Requirements
- R1: After a synchronous reset, `rx_ready`, `err_frame`, `err_parity` and `err_overrun` are 0 and `rd_data` is 0.
- R2: `rx_ready` is 1 exactly while the queue holds at least one unread character. The queue stores up to `DEPTH` characters, 2 by default, and returns them in arrival order. Each `rd_pop` pulse while `rx_ready` is 1 removes the head.
- R3: An `rd_pop` pulse while the queue is empty has no effect. A character received afterwards becomes the head, and a single read empties the queue again.
- R4: `err_frame` is 1 when the head character had its first stop bit sampled as 0 (`frm_stop_ok` = 0). It describes only that character and changes when the head is read.
- R5: `err_parity` is 1 for the head character only if `frm_par_bad` was 1 and `par_check` was 1 in the cycle that character was delivered.
- R6: An overrun is registered only when `start_det` pulses while the queue is full and the holding register still holds a waiting character. A start bit with an empty holding register raises nothing.
- R7: A registered overrun is tagged on the next character moved from the holding register into the queue. `err_overrun` is 1 while that character is the head. The pending overrun is cleared by that move, so later characters report 0.
- R8: A character delivered while the holding register is occupied and the queue cannot accept is lost. It never appears at `rd_data`.
- R9: `char_size` selects the width: 0=5, 1=6, 2=7, 3=8, 4=9 bits. Data bits at or above the selected width read as 0 at `rd_data`.
- R10: With `mpc_mode` = 1, only address characters are kept. The address marker is data bit 8 when `char_size` = 4, and `frm_addr` otherwise. Other characters are dropped.
- R11: While `rx_en` is 0, the queue, the holding register and any pending overrun are cleared and delivered characters are ignored. `rx_ready` is 0 from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 flushes all state |
| char_size | input | 3 | Character width code (0..4 = 5..9 bits) |
| par_check | input | 1 | Parity checking enabled |
| mpc_mode | input | 1 | Keep address characters only |
| start_det | input | 1 | Pulse: a new start bit was detected |
| frm_valid | input | 1 | Pulse: a decoded character is delivered |
| frm_data | input | DATA_W | Decoded character bits |
| frm_stop_ok | input | 1 | First stop bit sampled as 1 |
| frm_par_bad | input | 1 | Parity mismatch seen by the decoder |
| frm_addr | input | 1 | Address marker for widths below 9 |
| rd_pop | input | 1 | Read strobe; advances the queue |
| rd_data | output | DATA_W | Head character (0 when empty) |
| rx_ready | output | 1 | Queue holds unread data |
| err_frame | output | 1 | Frame error of the head character |
| err_parity | output | 1 | Parity error of the head character |
| err_overrun | output | 1 | Overrun tag of the head character |

## Verification
The bench builds the block with the default `DATA_W` = 9 and `DEPTH` = 2. With those values the full 9-bit path is exercised, including the address marker taken from bit 8. The shallow queue fills after two characters, so a third one parks in the holding register. That makes the full-queue overrun, the lost fourth character and the later release of the tagged character all reachable in a few reads. The tests also cover each width code, the empty-queue read and the flush while characters are queued.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [2:0] {
    CS_5 = 3'd0,
    CS_6 = 3'd1,
    CS_7 = 3'd2,
    CS_8 = 3'd3,
    CS_9 = 3'd4
  } char_size_e;

  // Number of valid data bits for a width code.
  function automatic int unsigned width_of(input logic [2:0] code);
    case (code)
      CS_5:    width_of = 5;
      CS_6:    width_of = 6;
      CS_7:    width_of = 7;
      CS_9:    width_of = 9;
      default: width_of = 8;
    endcase
  endfunction

endpackage

// File: rtl/rxq_capture.sv
module rxq_capture
  import uart_rxq_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int ENT_W = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [2:0]        char_size,
  input  logic              par_check,
  input  logic              mpc_mode,
  input  logic              start_det,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_stop_ok,
  input  logic              frm_par_bad,
  input  logic              frm_addr,
  input  logic              q_full,
  input  logic              q_pop,
  output logic              push,
  output logic [ENT_W-1:0]  push_entry,
  output logic              sh_full,
  output logic              ovr_pend
);

  logic [DATA_W-1:0] sh_data;
  logic              sh_fe;
  logic              sh_pe;
  logic [DATA_W-1:0] masked;
  logic              is_addr;
  logic              accept;
  logic              room;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = frm_data[i] && (i < int'(width_of(char_size)));
    end
  end

  assign is_addr = (char_size == CS_9) ? frm_data[DATA_W-1] : frm_addr;
  assign accept  = frm_valid && (!mpc_mode || is_addr);
  assign room    = !q_full || q_pop;
  assign push    = sh_full && room;

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      sh_full  <= 1'b0;
      ovr_pend <= 1'b0;
      sh_data  <= '0;
      sh_fe    <= 1'b0;
      sh_pe    <= 1'b0;
    end else begin
      if (start_det && sh_full && !room) begin
        ovr_pend <= 1'b1;
      end else if (push) begin
        ovr_pend <= 1'b0;
      end
      if (accept && (!sh_full || push)) begin
        sh_full <= 1'b1;
        sh_data <= masked;
        sh_fe   <= !frm_stop_ok;
        sh_pe   <= frm_par_bad && par_check;
      end else if (push) begin
        sh_full <= 1'b0;
      end
    end
  end

  assign push_entry = {ovr_pend, sh_pe, sh_fe, sh_data};

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int ENT_W = 12,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [ENT_W-1:0] wr_entry,
  input  logic             pop,
  output logic [ENT_W-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             pop_ok;
  logic             push_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign push_ok = push && (!full || pop_ok);

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    next_ptr = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage without reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr] <= wr_entry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2,
  localparam int ENT_W = DATA_W + 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [2:0]        char_size,
  input  logic              par_check,
  input  logic              mpc_mode,
  input  logic              start_det,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_stop_ok,
  input  logic              frm_par_bad,
  input  logic              frm_addr,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);

  logic             push;
  logic [ENT_W-1:0] push_entry;
  logic             sh_full;
  logic             ovr_pend;
  logic [ENT_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic             q_full;

  rxq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .char_size  (char_size),
    .par_check  (par_check),
    .mpc_mode   (mpc_mode),
    .start_det  (start_det),
    .frm_valid  (frm_valid),
    .frm_data   (frm_data),
    .frm_stop_ok(frm_stop_ok),
    .frm_par_bad(frm_par_bad),
    .frm_addr   (frm_addr),
    .q_full     (q_full),
    .q_pop      (rd_pop),
    .push       (push),
    .push_entry (push_entry),
    .sh_full    (sh_full),
    .ovr_pend   (ovr_pend)
  );

  rxq_fifo #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (!rx_en),
    .push    (push),
    .wr_entry(push_entry),
    .pop     (rd_pop),
    .head    (head),
    .count   (count),
    .full    (q_full)
  );

  assign rx_ready    = (count != '0);
  assign rd_data     = rx_ready ? head[DATA_W-1:0] : '0;
  assign err_frame   = rx_ready && head[DATA_W];
  assign err_parity  = rx_ready && head[DATA_W+1];
  assign err_overrun = rx_ready && head[DATA_W+2];

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic [2:0]        char_size,
  input logic              start_det,
  input logic              rd_pop,
  input logic              rx_ready,
  input logic              push,
  input logic [DATA_W-1:0] push_data,
  input logic              sh_full,
  input logic              ovr_pend,
  input logic [CNT_W-1:0]  count
);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
    rx_en && push && !rd_pop && (count < CNT_W'(DEPTH)) |=> count == $past(count) + 1'b1);

  p_empty_pop_r3: assert property (@(posedge clk) disable iff (rst)
    rx_en && rd_pop && (count == '0) && !push |=> count == '0);

  p_ovr_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_pend) |-> $past(start_det && sh_full && count == CNT_W'(DEPTH)));

  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    rx_en && ovr_pend && push |=> !ovr_pend);

  p_mask5_r9: assert property (@(posedge clk) disable iff (rst)
    push && $past(char_size) == 3'd0 && $stable(char_size) |-> push_data[DATA_W-1:5] == '0);

  p_flush_r11: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_ready && !sh_full && !ovr_pend);

endmodule

bind uart_rx_queue rxq_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_en    (rx_en),
  .char_size(char_size),
  .start_det(start_det),
  .rd_pop   (rd_pop),
  .rx_ready (rx_ready),
  .push     (push),
  .push_data(push_entry[DATA_W-1:0]),
  .sh_full  (sh_full),
  .ovr_pend (ovr_pend),
  .count    (count)
);

// File: tb/sim_uart_rx_queue.sv
`timescale 1ns/1ps
module sim_uart_rx_queue;

  localparam int DATA_W = 9;
  localparam int DEPTH  = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              rx_en;
  logic [2:0]        char_size;
  logic              par_check;
  logic              mpc_mode;
  logic              start_det;
  logic              frm_valid;
  logic [DATA_W-1:0] frm_data;
  logic              frm_stop_ok;
  logic              frm_par_bad;
  logic              frm_addr;
  logic              rd_pop;
  logic [DATA_W-1:0] rd_data;
  logic              rx_ready;
  logic              err_frame;
  logic              err_parity;
  logic              err_overrun;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_rx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; rx_en = 1'b1; char_size = 3'd3; par_check = 1'b0;
    mpc_mode = 1'b0; start_det = 1'b0; frm_valid = 1'b0; frm_data = '0;
    frm_stop_ok = 1'b1; frm_par_bad = 1'b0; frm_addr = 1'b0; rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Deliver one character; returns after the move into the queue could happen.
  task automatic send(input logic [DATA_W-1:0] d, input logic stop_ok,
                      input logic par_bad, input logic addr);
    frm_valid = 1'b1; frm_data = d; frm_stop_ok = stop_ok;
    frm_par_bad = par_bad; frm_addr = addr;
    @(negedge clk);
    frm_valid = 1'b0; frm_stop_ok = 1'b1; frm_par_bad = 1'b0; frm_addr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic head_is(input string req, input int d, input bit fe,
                         input bit pe, input bit ov);
    chk({req, " ready"}, rx_ready, 1);
    chk({req, " data"}, rd_data, d);
    chk({req, " fe"}, err_frame, fe);
    chk({req, " pe"}, err_parity, pe);
    chk({req, " ovr"}, err_overrun, ov);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ready", rx_ready, 0);
    chk("R1 data", rd_data, 0);
    chk("R1 flags", {err_frame, err_parity, err_overrun}, 0);
  endtask

  task automatic t_order();
    do_reset();
    send(9'h0A5, 1, 0, 0);
    send(9'h03C, 1, 0, 0);
    head_is("R2 first", 9'h0A5, 0, 0, 0);
    pop();
    head_is("R2 second", 9'h03C, 0, 0, 0);
    pop();
    chk("R2 empty", rx_ready, 0);
  endtask

  task automatic t_empty_pop();
    do_reset();
    pop();
    chk("R3 still empty", rx_ready, 0);
    send(9'h055, 1, 0, 0);
    head_is("R3 head", 9'h055, 0, 0, 0);
    pop();
    chk("R3 single read empties", rx_ready, 0);
  endtask

  task automatic t_errors();
    do_reset();
    send(9'h011, 0, 0, 0);
    send(9'h022, 1, 0, 0);
    head_is("R4 bad stop", 9'h011, 1, 0, 0);
    pop();
    head_is("R4 good stop", 9'h022, 0, 0, 0);
    pop();
    par_check = 1'b1;
    send(9'h033, 1, 1, 0);
    par_check = 1'b0;
    send(9'h044, 1, 1, 0);
    head_is("R5 checked", 9'h033, 0, 1, 0);
    pop();
    head_is("R5 unchecked", 9'h044, 0, 0, 0);
    pop();
  endtask

  task automatic t_overrun();
    do_reset();
    send(9'h0A1, 1, 0, 0);
    send(9'h0A2, 1, 0, 0);
    // Queue full, holding register empty: no overrun.
    start_det = 1'b1; @(negedge clk); start_det = 1'b0; @(negedge clk);
    send(9'h0A3, 1, 0, 0);
    start_det = 1'b1; @(negedge clk); start_det = 1'b0; @(negedge clk);
    send(9'h0A4, 1, 0, 0);
    head_is("R6 first", 9'h0A1, 0, 0, 0);
    pop();
    head_is("R6 second no ovr", 9'h0A2, 0, 0, 0);
    pop();
    head_is("R7 tagged", 9'h0A3, 0, 0, 1);
    pop();
    chk("R8 lost char absent", rx_ready, 0);
    send(9'h0A5, 1, 0, 0);
    head_is("R7 cleared", 9'h0A5, 0, 0, 0);
    pop();
  endtask

  task automatic t_overrun_none();
    do_reset();
    send(9'h0B1, 1, 0, 0);
    send(9'h0B2, 1, 0, 0);
    start_det = 1'b1; @(negedge clk); start_det = 1'b0; @(negedge clk);
    pop();
    pop();
    send(9'h0B3, 1, 0, 0);
    head_is("R6 no waiting char", 9'h0B3, 0, 0, 0);
    pop();
  endtask

  task automatic t_width();
    do_reset();
    for (int c = 0; c < 5; c++) begin
      char_size = 3'(c);
      send(9'h1FF, 1, 0, 0);
      head_is("R9 mask", (1 << (c + 5)) - 1, 0, 0, 0);
      pop();
    end
    char_size = 3'd3;
  endtask

  task automatic t_mpc();
    do_reset();
    mpc_mode = 1'b1;
    send(9'h012, 1, 0, 0);
    chk("R10 data frame dropped", rx_ready, 0);
    send(9'h013, 1, 0, 1);
    head_is("R10 address kept", 9'h013, 0, 0, 0);
    pop();
    char_size = 3'd4;
    send(9'h014, 1, 0, 1);
    chk("R10 nine-bit no marker dropped", rx_ready, 0);
    send(9'h115, 1, 0, 0);
    head_is("R10 nine-bit address", 9'h115, 0, 0, 0);
    pop();
    mpc_mode = 1'b0; char_size = 3'd3;
  endtask

  task automatic t_flush();
    do_reset();
    send(9'h061, 1, 0, 0);
    send(9'h062, 1, 0, 0);
    send(9'h063, 1, 0, 0);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R11 flushed", rx_ready, 0);
    send(9'h064, 1, 0, 0);
    chk("R11 ignored while off", rx_ready, 0);
    rx_en = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 nothing left", rx_ready, 0);
    send(9'h065, 1, 0, 0);
    head_is("R11 resumes", 9'h065, 0, 0, 0);
    pop();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_order();
        t_empty_pop();
        t_errors();
        t_overrun();
        t_overrun_none();
        t_width();
        t_mpc();
        t_flush();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule